// File: doc/BRIEF.md
# Non-maskable interrupt entry and return controller

This block is the trap-control slice of a small RISC-V-style core that deals only with non-maskable interrupts. When the request line is high at a rising clock edge, the controller abandons the current program and takes the interrupt. It does this whatever the interrupt-enable state is. In that one edge it does all of the following:
- saves the current PC as the exception PC;
- writes the cause code;
- pushes the status bits and the privilege level;
- moves to machine privilege;
- records the handler sub-mode;
- issues a one-cycle redirect to the handler address.

A single shared-vector control bit picks two things together: the handler address (the trap-vector value or the reset-vector input) and the cause code. On a trap-return strobe, the block undoes the entry in one edge:
- it redirects to the saved exception PC;
- it pops the status bits and the privilege level;
- it restores the earlier sub-mode from its saved copy.

The block saves and restores no general-purpose register context. Software in the handler must do that. Every result is held in a register and appears one clock after the edge that samples the stimulus.

Top module: `nmi_trap_ctl`

## Requirements
- R1: While rst_n is low and after its release, the state is: redirect = 0, redirect_pc = 0, exc_pc = 0, exc_code = 0, ie = 0, pie = 1, priv_lvl = 3 (machine), prev_priv = 0 (user), submode = 0.
- R2: A high nmi_req at a rising edge is always taken, even when ie = 1. It makes redirect high for the following cycle.
- R3: On an entry with vec_shared = 1, redirect_pc becomes trap_vec and exc_code becomes 0xfff.
- R4: On an entry with vec_shared = 0, redirect_pc becomes rst_vec and exc_code becomes 0x001.
- R5: On entry, exc_pc captures cur_pc.
- R6: On entry, pie takes ie, ie clears, prev_priv takes priv_lvl, and priv_lvl becomes 3.
- R7: submode holds the current type in bits [7:6] and the previous type in bits [9:8]. All its other bits read 0. The type encoding is 0 normal, 1 interrupt, 2 exception, 3 NMI. On entry, the previous field takes the current type and the type becomes 3.
- R8: A high mret without nmi_req has the following effects: redirect goes high, redirect_pc becomes exc_pc, ie takes pie, pie becomes 1, priv_lvl takes prev_priv, prev_priv becomes 0, and the type field reloads from the previous field. The previous field and exc_pc are unchanged.
- R9: When nmi_req and mret are both high, the entry wins and exc_pc captures cur_pc, which is the PC of the return instruction.
- R10: With neither nmi_req nor mret high, redirect is 0 and every CSR output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mret | input | 1 | Trap-return strobe |
| cur_pc | input | XLEN | PC of the instruction being abandoned |
| rst_vec | input | XLEN | Reset-vector address |
| trap_vec | input | XLEN | Current trap-vector register value |
| vec_shared | input | 1 | 1: handler at trap_vec with code 0xfff; 0: handler at rst_vec with code 0x1 |
| redirect | output | 1 | One-cycle PC redirect strobe |
| redirect_pc | output | XLEN | Redirect target |
| exc_pc | output | XLEN | Saved exception PC |
| exc_code | output | CODE_W | Cause exception code |
| ie | output | 1 | Machine interrupt enable |
| pie | output | 1 | Previous interrupt enable |
| priv_lvl | output | 2 | Current privilege level |
| prev_priv | output | 2 | Previous privilege level |
| submode | output | 10 | Sub-mode register (type [7:6], previous type [9:8]) |

## Verification
Each result of an entry or a return is due one rising edge after the edge at which nmi_req or mret is sampled high. The redirect strobe drops again one edge later unless another event follows. The bench drives inputs on the falling edge and advances its behavioural model at the next rising edge. It then compares every output at the falling edge after that, so each check lands exactly one register stage after its stimulus. The checker properties use the same one-edge spacing, through |=> and $past.

// File: rtl/nmi_trap_ctl.sv
module nmi_trap_ctl #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] CODE_SHARED = 12'hfff,
  parameter logic [CODE_W-1:0] CODE_OWN    = 12'h001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic              mret,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   rst_vec,
  input  logic [XLEN-1:0]   trap_vec,
  input  logic              vec_shared,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   exc_pc,
  output logic [CODE_W-1:0] exc_code,
  output logic              ie,
  output logic              pie,
  output logic [1:0]        priv_lvl,
  output logic [1:0]        prev_priv,
  output logic [9:0]        submode
);
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] SM_NMI = 2'd3;

  logic [1:0] sm_type, sm_prev;
  logic       take_ret;

  assign take_ret = mret & ~nmi_req;
  assign submode  = {sm_prev, sm_type, 6'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      exc_pc      <= '0;
      exc_code    <= '0;
      ie          <= 1'b0;
      pie         <= 1'b1;
      priv_lvl    <= PRIV_M;
      prev_priv   <= PRIV_U;
      sm_type     <= 2'd0;
      sm_prev     <= 2'd0;
    end else if (nmi_req) begin
      redirect    <= 1'b1;
      redirect_pc <= vec_shared ? trap_vec : rst_vec;
      exc_code    <= vec_shared ? CODE_SHARED : CODE_OWN;
      exc_pc      <= cur_pc;
      pie         <= ie;
      ie          <= 1'b0;
      prev_priv   <= priv_lvl;
      priv_lvl    <= PRIV_M;
      sm_prev     <= sm_type;
      sm_type     <= SM_NMI;
    end else if (take_ret) begin
      redirect    <= 1'b1;
      redirect_pc <= exc_pc;
      ie          <= pie;
      pie         <= 1'b1;
      priv_lvl    <= prev_priv;
      prev_priv   <= PRIV_U;
      sm_type     <= sm_prev;
    end else begin
      redirect    <= 1'b0;
    end
  end
endmodule

module nmi_trap_ctl_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_req,
  input logic              mret,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   rst_vec,
  input logic [XLEN-1:0]   trap_vec,
  input logic              vec_shared,
  input logic              redirect,
  input logic [XLEN-1:0]   redirect_pc,
  input logic [XLEN-1:0]   exc_pc,
  input logic [CODE_W-1:0] exc_code,
  input logic              ie,
  input logic              pie,
  input logic [1:0]        priv_lvl,
  input logic [1:0]        prev_priv,
  input logic [9:0]        submode
);
  assert_nmi_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> redirect);
  assert_shared_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && vec_shared) |=> (redirect_pc == $past(trap_vec)) && (exc_code == 12'hfff));
  assert_own_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !vec_shared) |=> (redirect_pc == $past(rst_vec)) && (exc_code == 12'h001));
  assert_epc_save_R5_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> exc_pc == $past(cur_pc));
  assert_status_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> (priv_lvl == 2'd3) && !ie && (pie == $past(ie)) && (prev_priv == $past(priv_lvl)));
  assert_submode_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> (submode[7:6] == 2'd3) && (submode[9:8] == $past(submode[7:6])));
  assert_submode_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    submode[5:0] == 6'b0);
  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !nmi_req) |=> redirect && (redirect_pc == $past(exc_pc)) && (ie == $past(pie))
      && pie && (priv_lvl == $past(prev_priv)) && (prev_priv == 2'd0)
      && (submode[7:6] == $past(submode[9:8])) && $stable(exc_pc));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && !mret) |=> !redirect && $stable(exc_pc) && $stable(exc_code) && $stable(ie)
      && $stable(pie) && $stable(priv_lvl) && $stable(prev_priv) && $stable(submode));
endmodule

bind nmi_trap_ctl nmi_trap_ctl_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/nmi_trap_ctl_bench.sv
`timescale 1ns/1ps
module nmi_trap_ctl_bench;
  localparam int XLEN = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_req = 0, mret = 0, vec_shared = 0;
  logic [XLEN-1:0] cur_pc = 0, rst_vec = 32'h0000_1000, trap_vec = 32'h8000_0040;
  logic redirect, ie, pie;
  logic [XLEN-1:0] redirect_pc, exc_pc;
  logic [11:0] exc_code;
  logic [1:0] priv_lvl, prev_priv;
  logic [9:0] submode;

  int checks = 0, errors = 0, cycles = 0;

  logic m_redir, m_ie, m_pie;
  logic [XLEN-1:0] m_rpc, m_epc;
  logic [11:0] m_code;
  logic [1:0] m_priv, m_pp, m_type, m_prev;

  always #2.5 clk = ~clk;

  nmi_trap_ctl u_nmi_trap_ctl (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "redirect", redirect, m_redir);
    chk(tag, "redirect_pc", redirect_pc, m_rpc);
    chk(tag, "exc_pc", exc_pc, m_epc);
    chk(tag, "exc_code", exc_code, m_code);
    chk(tag, "ie", ie, m_ie);
    chk(tag, "pie", pie, m_pie);
    chk(tag, "priv_lvl", priv_lvl, m_priv);
    chk(tag, "prev_priv", prev_priv, m_pp);
    chk(tag, "submode", submode, {m_prev, m_type, 6'b0});
  endtask

  task automatic model_reset();
    m_redir = 0; m_rpc = 0; m_epc = 0; m_code = 0;
    m_ie = 0; m_pie = 1; m_priv = 3; m_pp = 0; m_type = 0; m_prev = 0;
  endtask

  task automatic cyc(logic n, logic r, logic [XLEN-1:0] pc, logic sh, string tag);
    nmi_req = n; mret = r; cur_pc = pc; vec_shared = sh;
    @(posedge clk);
    if (n) begin
      m_redir = 1;
      m_rpc = sh ? trap_vec : rst_vec;
      m_code = sh ? 12'hfff : 12'h001;
      m_epc = pc;
      m_pie = m_ie; m_ie = 0;
      m_pp = m_priv; m_priv = 3;
      m_prev = m_type; m_type = 3;
    end else if (r) begin
      m_redir = 1;
      m_rpc = m_epc;
      m_ie = m_pie; m_pie = 1;
      m_priv = m_pp; m_pp = 0;
      m_type = m_prev;
    end else begin
      m_redir = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    logic [31:0] lcg;
    string tag;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    cyc(0, 0, 32'h10, 0, "R1");
    cyc(0, 0, 32'h14, 0, "R10");
    cyc(0, 1, 32'h18, 0, "R8");
    cyc(0, 0, 32'h1c, 0, "R10");
    cyc(1, 0, 32'h200, 1, "R2_R3_R6");
    cyc(0, 0, 32'h204, 1, "R10");
    cyc(1, 0, 32'h300, 0, "R4_R5_R7");
    cyc(0, 1, 32'h304, 0, "R8");
    cyc(0, 1, 32'h308, 0, "R8");
    cyc(1, 1, 32'h400, 1, "R9");
    cyc(0, 1, 32'h404, 1, "R8");
    trap_vec = 32'h0000_2200; rst_vec = 32'h0000_0080;
    cyc(1, 0, 32'h500, 1, "R3");
    cyc(1, 0, 32'h600, 0, "R4_R7");
    lcg = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[20] && lcg[21]) trap_vec = {lcg[31:4], 4'b0};
      if (lcg[22] && lcg[23]) rst_vec = {lcg[15:4], 4'b0, lcg[31:16]};
      if (lcg[29] && lcg[28]) tag = "R9";
      else if (lcg[29]) tag = "R2";
      else if (lcg[28]) tag = "R8";
      else tag = "R10";
      cyc(lcg[29], lcg[28], {lcg[27:2], 2'b0}, lcg[26], tag);
    end
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    compare("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule